// File: doc/BRIEF.md
# Masked-Domain Secure Execution Unit

This block is a single-cycle execution unit that only ever handles Boolean-masked 32-bit words. A caller presents two masked operands and, for each one, the index of the entry in an internal mask store that holds its mask. The unit recovers the true operands inside itself, applies the selected operation, and returns the result masked with a fresh mask. The fresh mask comes from an internal pseudo-random generator and is written into the store entry named by the result index. The mask itself stays in the store and never leaves the unit.

The operation set covers bitwise logic, modular add and subtract, logical shifts, and rotate right. Two add variants use a carry flag that is held privately in the unit, so wider additions can be chained one word at a time. The carry can be saved as a masked word and restored from one, which supports context switches. The flag is never exposed in plain form. Shift and rotate amounts come from a plain 5-bit immediate, because they are not secret.

Top module: `masked_exec_unit`

## Requirements
- R1: After reset, out_valid is 0, res_m is 0, every mask-store entry holds 0, the carry flag is 0 and the mask generator holds its seed (default 32'h2545F491).
- R2: The true value of an operand is its masked input XOR the store entry at its index. One cycle after an accepted result-producing operation, res_m equals the true result XOR the fresh mask, and that fresh mask is in store entry res_idx in time for the next operation.
- R3: The fresh mask is the generator's current state. The state then advances by one xorshift step (s ^= s<<13; s ^= s>>17; s ^= s<<5). It advances only when a result is produced.
- R4: Operation codes 0, 1 and 2 give the bitwise XOR, AND and OR of the true operands.
- R5: Code 3 gives A+B and code 4 gives A-B, both modulo 2^32. Neither changes the carry flag.
- R6: Code 5 shifts A left logically, code 6 shifts A right logically and code 7 rotates A right. In each case the amount is the plain 5-bit shamt input, and an amount of 0 returns A unchanged.
- R7: Code 8 gives A+B and loads the carry flag with the carry out of bit 31. Code 9 gives A+B+carry and loads the carry flag with its own carry out.
- R8: Code 10 returns the carry flag zero-extended to 32 bits as a masked result. Code 11 loads the carry flag from bit 0 of the true A operand; it produces no result, writes no store entry and does not step the generator.
- R9: Codes 12 to 15, and any cycle with in_valid low, produce no result and change no store entry, no carry and no generator state.
- R10: out_valid is high exactly in the cycle after a result-producing operation is accepted, and res_m is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 4 | Operation select |
| opa_m | input | 32 | Masked operand A |
| opa_idx | input | 5 | Mask-store index of operand A |
| opb_m | input | 32 | Masked operand B |
| opb_idx | input | 5 | Mask-store index of operand B |
| shamt | input | 5 | Plain shift or rotate amount |
| res_idx | input | 5 | Mask-store entry that receives the fresh mask |
| out_valid | output | 1 | Result is valid |
| res_m | output | 32 | Masked result |

## Verification
The hardest state to reach from the ports is the inside of the unit: the mask-store contents, the generator state and the carry flag never appear on an output. The bench keeps its own model of all three. It builds every masked operand from the masks that model holds, so a wrong store write, a stray generator step or a lost carry shows up as a wrong result on a later operation. Ignored codes, idle cycles and carry restores are each followed directly by operations that depend on the state they must leave alone or change. A long pseudo-random stream then reuses result indices as operand indices back to back.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_XOR   = 4'd0,
      OP_AND   = 4'd1,
      OP_OR    = 4'd2,
      OP_ADD   = 4'd3,
      OP_SUB   = 4'd4,
      OP_SLL   = 4'd5,
      OP_SRL   = 4'd6,
      OP_ROTR  = 4'd7,
      OP_ADDCC = 4'd8,
      OP_ADDX  = 4'd9,
      OP_CSAVE = 4'd10,
      OP_CLOAD = 4'd11
   } mfu_op_e;

   localparam int GEN_XORSHIFT = 0;
   localparam int GEN_LFSR     = 1;

   function automatic logic op_makes_result(input logic [OP_W-1:0] code);
      return (code <= OP_CSAVE);
   endfunction

   function automatic logic op_touches_carry(input logic [OP_W-1:0] code);
      return (code == OP_ADDCC) || (code == OP_ADDX) || (code == OP_CLOAD);
   endfunction
endpackage

// File: rtl/mfu_mask_store.sv
module mfu_mask_store #(
   parameter int W     = 32,
   parameter int DEPTH = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [W-1:0]     ra_mask,
   output logic [W-1:0]     rb_mask,
   input  logic             we,
   input  logic [IDX_W-1:0] wa_idx,
   input  logic [W-1:0]     wdata
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("mfu_mask_store: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n)
            mem_q[i] <= '0;
         else if (we && wa_idx == IDX_W'(i))
            mem_q[i] <= wdata;
      end
   end

   assign ra_mask = mem_q[ra_idx];
   assign rb_mask = mem_q[rb_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && wa_idx == IDX_W'(g)) |=> $stable(mem_q[g])); // R9
      AST_ENTRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wa_idx == IDX_W'(g)) |=> mem_q[g] == $past(wdata)); // R2
   end
endmodule

// File: rtl/mfu_mask_gen.sv
module mfu_mask_gen #(
   parameter int           W    = 32,
   parameter int           KIND = mfu_pkg::GEN_XORSHIFT,
   parameter logic [W-1:0] SEED = 32'h2545_F491,
   parameter logic [W-1:0] POLY = 32'h8020_0003
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] mask
);
   if (SEED == '0) begin : g_bad_seed
      $error("mfu_mask_gen: SEED must be non-zero");
   end
   if (KIND != mfu_pkg::GEN_XORSHIFT && KIND != mfu_pkg::GEN_LFSR) begin : g_bad_kind
      $error("mfu_mask_gen: unknown KIND");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] state_nxt;

   if (KIND == mfu_pkg::GEN_XORSHIFT) begin : g_xs
      if (W != 32) begin : g_bad_w
         $error("mfu_mask_gen: xorshift variant needs W == 32");
      end
      logic [W-1:0] t1, t2;
      always_comb begin
         t1        = state_q ^ (state_q << 13);
         t2        = t1 ^ (t1 >> 17);
         state_nxt = t2 ^ (t2 << 5);
      end
   end else begin : g_lfsr
      always_comb begin
         state_nxt = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? POLY : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= SEED;
      else if (step)
         state_q <= state_nxt;
   end

   assign mask = state_q;

   AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state_q)); // R3
   AST_GEN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> state_q != $past(state_q)); // R3
   AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R3
endmodule

// File: rtl/mfu_exec.sv
module mfu_exec
   import mfu_pkg::*;
#(
   parameter int W = 32,
   localparam int SH_W = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic [SH_W-1:0] shamt,
   output logic [W-1:0]    result
);
   if ((1 << SH_W) != W) begin : g_bad_w
      $error("mfu_exec: W must be a power of two");
   end

   logic         carry_q;
   logic [W:0]   sum_plain;
   logic [W:0]   sum_chain;
   logic [2*W-1:0] rot_dbl;

   always_comb begin
      sum_plain = {1'b0, a} + {1'b0, b};
      sum_chain = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_q};
      rot_dbl   = {a, a} >> shamt;
   end

   always_comb begin
      unique case (mfu_op_e'(op))
         OP_XOR:   result = a ^ b;
         OP_AND:   result = a & b;
         OP_OR:    result = a | b;
         OP_ADD:   result = sum_plain[W-1:0];
         OP_SUB:   result = a - b;
         OP_SLL:   result = a << shamt;
         OP_SRL:   result = a >> shamt;
         OP_ROTR:  result = rot_dbl[W-1:0];
         OP_ADDCC: result = sum_plain[W-1:0];
         OP_ADDX:  result = sum_chain[W-1:0];
         OP_CSAVE: result = {{(W-1){1'b0}}, carry_q};
         default:  result = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         carry_q <= 1'b0;
      else if (fire) begin
         case (mfu_op_e'(op))
            OP_ADDCC: carry_q <= sum_plain[W];
            OP_ADDX:  carry_q <= sum_chain[W];
            OP_CLOAD: carry_q <= a[0];
            default:  carry_q <= carry_q;
         endcase
      end
   end

   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && op_touches_carry(op)) |=> $stable(carry_q)); // R5
   AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_CLOAD) |=> carry_q == $past(a[0])); // R8
endmodule

// File: rtl/masked_exec_unit.sv
module masked_exec_unit
   import mfu_pkg::*;
#(
   parameter int           DATA_W   = 32,
   parameter int           DEPTH    = 32,
   parameter int           GEN_KIND = GEN_XORSHIFT,
   parameter logic [31:0]  GEN_SEED = 32'h2545_F491,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic [DATA_W-1:0] opa_m,
   input  logic [IDX_W-1:0]  opa_idx,
   input  logic [DATA_W-1:0] opb_m,
   input  logic [IDX_W-1:0]  opb_idx,
   input  logic [SH_W-1:0]   shamt,
   input  logic [IDX_W-1:0]  res_idx,
   output logic              out_valid,
   output logic [DATA_W-1:0] res_m
);
   if (DATA_W < 8) begin : g_bad_w
      $error("masked_exec_unit: DATA_W too small");
   end

   logic [DATA_W-1:0] mask_a, mask_b, fresh_mask;
   logic [DATA_W-1:0] plain_a, plain_b, plain_res;
   logic              fire_any, fire_res;

   assign fire_any = in_valid;
   assign fire_res = in_valid && op_makes_result(op_code);

   mfu_mask_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (opa_idx),
      .rb_idx  (opb_idx),
      .ra_mask (mask_a),
      .rb_mask (mask_b),
      .we      (fire_res),
      .wa_idx  (res_idx),
      .wdata   (fresh_mask)
   );

   mfu_mask_gen #(.W(DATA_W), .KIND(GEN_KIND), .SEED(DATA_W'(GEN_SEED))) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (fire_res),
      .mask  (fresh_mask)
   );

   assign plain_a = opa_m ^ mask_a;
   assign plain_b = opb_m ^ mask_b;

   mfu_exec #(.W(DATA_W)) u_exec (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire_any),
      .op     (op_code),
      .a      (plain_a),
      .b      (plain_b),
      .shamt  (shamt),
      .result (plain_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_m     <= '0;
      end else begin
         out_valid <= fire_res;
         res_m     <= fire_res ? (plain_res ^ fresh_mask) : '0;
      end
   end

   AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      fire_res |=> out_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_res |=> (!out_valid && res_m == '0)); // R9
endmodule

// File: tb/tb_masked_exec_unit.sv
`timescale 1ns/1ps
module tb_masked_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [3:0]  op_code;
   logic [31:0] opa_m, opb_m;
   logic [4:0]  opa_idx, opb_idx, shamt, res_idx;
   logic        out_valid;
   logic [31:0] res_m;

   always #2 clk = ~clk;

   masked_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .opa_m(opa_m), .opa_idx(opa_idx), .opb_m(opb_m), .opb_idx(opb_idx),
      .shamt(shamt), .res_idx(res_idx), .out_valid(out_valid), .res_m(res_m)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // behavioural model state
   logic [31:0] m_mask [32];
   logic        m_carry;
   logic [31:0] m_gen;
   logic        e_valid;
   logic [31:0] e_res;
   string       e_tag;

   function automatic logic [31:0] xs_step(input logic [31:0] x);
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m_mask[i] = 32'h0;
      m_carry = 1'b0;
      m_gen   = 32'h2545_F491;
      e_valid = 1'b0;
      e_res   = 32'h0;
      e_tag   = "R1";
   endtask

   task automatic compare();
      checks++;
      if (out_valid !== e_valid) begin
         errors++;
         $display("FAIL %s out_valid got %0b exp %0b", e_tag, out_valid, e_valid);
      end
      checks++;
      if (res_m !== e_res) begin
         errors++;
         $display("FAIL %s res_m got %h exp %h", e_tag, res_m, e_res);
      end
   endtask

   // one clock: check previous expectation, drive new op, update model
   task automatic step(input logic v, input logic [3:0] o,
                       input logic [31:0] ta, input logic [4:0] ia,
                       input logic [31:0] tb, input logic [4:0] ib,
                       input logic [4:0] sh, input logic [4:0] ri,
                       input string tag);
      logic [31:0] r;
      logic [32:0] s;
      logic        makes;
      @(negedge clk);
      compare();
      in_valid = v;
      op_code  = o;
      opa_m    = ta ^ m_mask[ia];
      opb_m    = tb ^ m_mask[ib];
      opa_idx  = ia;
      opb_idx  = ib;
      shamt    = sh;
      res_idx  = ri;
      r = 32'h0;
      makes = v && (o <= 4'd10);
      if (v) begin
         case (o)
            4'd0:  r = ta ^ tb;
            4'd1:  r = ta & tb;
            4'd2:  r = ta | tb;
            4'd3:  r = ta + tb;
            4'd4:  r = ta - tb;
            4'd5:  r = ta << sh;
            4'd6:  r = ta >> sh;
            4'd7:  r = (sh == 0) ? ta : ((ta >> sh) | (ta << (32 - sh)));
            4'd8:  begin s = {1'b0, ta} + {1'b0, tb}; r = s[31:0]; m_carry = s[32]; end
            4'd9:  begin s = {1'b0, ta} + {1'b0, tb} + {32'h0, m_carry};
                         r = s[31:0]; m_carry = s[32]; end
            4'd10: r = {31'h0, m_carry};
            4'd11: m_carry = ta[0];
            default: r = 32'h0;
         endcase
      end
      if (makes) begin
         e_valid    = 1'b1;
         e_res      = r ^ m_gen;
         m_mask[ri] = m_gen;
         m_gen      = xs_step(m_gen);
      end else begin
         e_valid = 1'b0;
         e_res   = 32'h0;
      end
      e_tag = tag;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 4'hF, 32'hDEAD_BEEF, 5'd3, 32'h1234_5678, 5'd4, 5'd7, 5'd3, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   logic [31:0] lcg;

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; op_code = '0; opa_m = '0; opb_m = '0;
      opa_idx = '0; opb_idx = '0; shamt = '0; res_idx = '0;
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset outputs, zero store entries, seed in generator
      idle("R1");
      step(1, 4'd0, 32'hA5A5_0F0F, 5'd1, 32'h0000_FFFF, 5'd2, 5'd0, 5'd10, "R1");
      // R4: logic ops, several patterns
      step(1, 4'd0, 32'hFFFF_0000, 5'd10, 32'h0F0F_0F0F, 5'd5, 5'd0, 5'd11, "R4");
      step(1, 4'd1, 32'hF0F0_F0F0, 5'd11, 32'h3C3C_3C3C, 5'd10, 5'd0, 5'd12, "R4");
      step(1, 4'd2, 32'h8000_0001, 5'd12, 32'h0000_0100, 5'd12, 5'd0, 5'd12, "R4");
      // R2: result index equals operand index, back to back reuse
      step(1, 4'd0, 32'h1357_9BDF, 5'd12, 32'h2468_ACE0, 5'd11, 5'd0, 5'd12, "R2");
      step(1, 4'd3, 32'h0000_0001, 5'd12, 32'h0000_0001, 5'd12, 5'd0, 5'd13, "R2");
      // R5: add and subtract wrap
      step(1, 4'd3, 32'hFFFF_FFFF, 5'd13, 32'h0000_0002, 5'd14, 5'd0, 5'd14, "R5");
      step(1, 4'd4, 32'h0000_0000, 5'd14, 32'h0000_0001, 5'd15, 5'd0, 5'd15, "R5");
      step(1, 4'd10, 32'h0, 5'd0, 32'h0, 5'd0, 5'd0, 5'd16, "R5"); // carry still 0
      // R6: shifts and rotate, amount edges
      step(1, 4'd5, 32'h8000_0003, 5'd1, 32'h0, 5'd0, 5'd0,  5'd17, "R6");
      step(1, 4'd5, 32'h8000_0003, 5'd1, 32'h0, 5'd0, 5'd31, 5'd17, "R6");
      step(1, 4'd6, 32'h8000_0003, 5'd1, 32'h0, 5'd0, 5'd31, 5'd18, "R6");
      step(1, 4'd6, 32'hC000_0000, 5'd1, 32'h0, 5'd0, 5'd4,  5'd18, "R6");
      step(1, 4'd7, 32'h8765_4321, 5'd1, 32'h0, 5'd0, 5'd0,  5'd19, "R6");
      step(1, 4'd7, 32'h8765_4321, 5'd1, 32'h0, 5'd0, 5'd1,  5'd19, "R6");
      step(1, 4'd7, 32'h8765_4321, 5'd1, 32'h0, 5'd0, 5'd31, 5'd19, "R6");
      // R7: 64-bit add from two words, carry set then used
      step(1, 4'd8, 32'hFFFF_FFFF, 5'd20, 32'h0000_0001, 5'd21, 5'd0, 5'd22, "R7");
      step(1, 4'd9, 32'h0000_0005, 5'd20, 32'h0000_0007, 5'd21, 5'd0, 5'd23, "R7");
      step(1, 4'd9, 32'hFFFF_FFFF, 5'd20, 32'h0000_0000, 5'd21, 5'd0, 5'd24, "R7");
      step(1, 4'd8, 32'hFFFF_FFFF, 5'd22, 32'hFFFF_FFFF, 5'd23, 5'd0, 5'd25, "R7");
      // R8: save carry (1), restore 0, then ADDX shows cleared carry
      step(1, 4'd10, 32'h0, 5'd0, 32'h0, 5'd0, 5'd0, 5'd26, "R8");
      step(1, 4'd11, 32'hFFFF_FFFE, 5'd25, 32'h0, 5'd0, 5'd0, 5'd26, "R8");
      step(1, 4'd9, 32'h0000_0010, 5'd26, 32'h0000_0020, 5'd25, 5'd0, 5'd27, "R8");
      step(1, 4'd11, 32'h0000_0001, 5'd27, 32'h0, 5'd0, 5'd0, 5'd27, "R8");
      step(1, 4'd10, 32'h0, 5'd0, 32'h0, 5'd0, 5'd0, 5'd28, "R8");
      // R9: ignored codes and idle cycle, then dependent ops
      step(1, 4'd12, 32'h1111_1111, 5'd28, 32'h2, 5'd27, 5'd3, 5'd28, "R9");
      step(1, 4'd13, 32'h3333_3333, 5'd28, 32'h4, 5'd27, 5'd3, 5'd27, "R9");
      step(1, 4'd14, 32'h0000_0000, 5'd28, 32'hFFFF_FFFF, 5'd27, 5'd3, 5'd28, "R9");
      step(1, 4'd15, 32'h0000_0001, 5'd28, 32'h1, 5'd27, 5'd3, 5'd28, "R9");
      idle("R9");
      step(1, 4'd9, 32'h0000_0000, 5'd28, 32'h0000_0000, 5'd27, 5'd0, 5'd29, "R9");
      // R10: output drops after a lone result
      step(1, 4'd0, 32'h0BAD_F00D, 5'd29, 32'h0, 5'd30, 5'd0, 5'd30, "R10");
      idle("R10");
      idle("R10");
      // R2: pseudo-random stream
      lcg = 32'h1;
      for (int k = 0; k < 400; k++) begin
         logic [31:0] va, vb, ctl;
         lcg = lcg * 32'd1664525 + 32'd1013904223; va  = lcg;
         lcg = lcg * 32'd1664525 + 32'd1013904223; vb  = lcg;
         lcg = lcg * 32'd1664525 + 32'd1013904223; ctl = lcg;
         step(ctl[31:29] != 3'd0, ctl[3:0], va, ctl[8:4], vb, ctl[13:9],
              ctl[18:14], ctl[23:19], "R2");
      end
      idle("R10");
      @(negedge clk);
      compare();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule